// File: doc/BRIEF.md
# Console Character Input Staging

This block moves typed characters from a keyboard source into storage through two holding registers. A character accepted from the keyboard stream lands in the first holding register (the hold stage), which raises a full flag. From there it is loaded into a second register (the transfer stage), which presents it to storage as a write request at the current buffer address. The address starts at a value given with the start pulse and steps by one after every completed write.

The hold-stage full flag is set by every accepted character. It is cleared by a copy of the transfer-stage load strobe that is delayed by one clock. If a new character is accepted in the same clock as that delayed clear, the set wins and the flag stays high with the new character. The keyboard may therefore deliver one character every two clocks with no gap in the flag.

An input operation ends in one of three ways:
- **Release key:** stops acceptance, writes out every character still held, then reports normal completion.
- **Cancel key:** stops at once, discards held characters and reports an abort.
- **Buffer end:** the storage location about to be written holds the group-mark code together with a word mark. That location is left untouched, held characters are discarded, and a buffer-end completion is reported.

Back-pressure rules:
- The keyboard stream is valid/ready. A character moves on a clock edge where both are high.
- `kb_ready` is low whenever the hold stage is full and its delayed clear is not active in that cycle, and always low outside an active operation. A source must hold `kb_data` stable while `kb_valid` is high and `kb_ready` is low.
- The storage write is valid/ready. `wr_valid` stays high with stable `wr_addr` and `wr_data` until `wr_ready` is seen.

Top module: `kbd_stage_in`

## Requirements
- R1: After synchronous active-high reset, `busy`, `done`, `kb_ready`, `wr_valid` and `hold_full` are all 0.
- R2: A character accepted on a clock edge makes `hold_full` read 1 after that edge.
- R3: The transfer-stage load strobe fires at most once per character: never in two consecutive cycles. Each accepted character produces exactly one storage write.
- R4: With no new character accepted, `hold_full` stays 1 for exactly two cycles after the accepting edge and reads 0 after the third edge. This holds when the transfer stage is free and `wr_ready` is 1.
- R5: When a character is accepted in the cycle where the delayed clear is active, `hold_full` stays 1. The new character is later written in order with no loss.
- R6: `kb_ready` is 0 while `hold_full` is 1 and the delayed clear is inactive. A character held off this way is not dropped.
- R7: Characters are written to consecutive addresses beginning at `start_addr`, in typing order.
- R8: A release key stops acceptance from the next cycle. All held characters are still written, then `done` pulses with `end_code` = 0.
- R9: A cancel key stops acceptance and discards held characters: no storage write follows it. `done` pulses with `end_code` = 1 and `busy` falls.
- R10: When the transfer stage holds a character and the current location reports `mark_char` = `GM_CODE` with `mark_wm` = 1, nothing is written there. `done` pulses with `end_code` = 2 and `busy` falls.
- R11: A `start` pulse while `busy` is 1 is ignored: the write address sequence is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an input operation (taken only when idle) |
| start_addr | input | AW | First buffer address |
| key_release | input | 1 | Operator release key |
| key_cancel | input | 1 | Operator cancel key |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| end_code | output | 2 | 0 release, 1 cancel, 2 buffer end; held until next start |
| kb_valid | input | 1 | Keyboard character valid |
| kb_ready | output | 1 | Block can take a character |
| kb_data | input | CW | Keyboard character |
| hold_full | output | 1 | Hold-stage full flag |
| wr_valid | output | 1 | Storage write request |
| wr_ready | input | 1 | Storage accepts the write |
| wr_addr | output | AW | Current buffer address (also the marker probe address) |
| wr_data | output | CW | Character to write |
| mark_char | input | CW | Character currently stored at `wr_addr` |
| mark_wm | input | 1 | Word-mark bit currently stored at `wr_addr` |

## Verification
Characters are typed with idle gaps, which isolates the flag's set and delayed clear in time. They are also streamed back to back with `kb_valid` held high, which forces the same-cycle set and clear and shows whether set dominance keeps every character. A stalled storage port holds both stages full and separates correct back-pressure from silent overwrite. The release, cancel and buffer-end endings are each run with characters still pending. These runs tell draining apart from discarding, and show whether the marked location is left untouched.

// File: rtl/kin_pkg.sv
package kin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } kin_state_t;

  typedef enum logic [1:0] {
    END_RELEASE = 2'd0,
    END_CANCEL  = 2'd1,
    END_BUFEND  = 2'd2
  } kin_end_t;

endpackage

// File: rtl/kin_hold_stage.sv
// First holding register with its full flag.
// Conflict rule: flush beats everything, then set beats the delayed clear.
module kin_hold_stage #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [CW-1:0] din,
  output logic          full_o,
  output logic [CW-1:0] dout
);

  logic          full_q;
  logic [CW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      full_q <= 1'b0;
    end else if (set_i) begin
      full_q <= 1'b1;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (set_i) begin
      data_q <= din;
    end
  end

  assign full_o = full_q;
  assign dout   = data_q;

endmodule

// File: rtl/kin_xfer_stage.sv
// Second register: one load strobe per character, a delayed copy of it
// for the hold-stage clear, and the storage write request.
module kin_xfer_stage #(
  parameter int          CW      = 8,
  parameter logic [CW-1:0] GM_CODE = 8'h3A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          run,
  input  logic          hold_full,
  input  logic [CW-1:0] hold_data,
  input  logic [CW-1:0] mark_char,
  input  logic          mark_wm,
  input  logic          wr_ready,
  output logic          ld,
  output logic          ld_dly,
  output logic          full_o,
  output logic          at_mark,
  output logic          wr_valid,
  output logic          wr_fire,
  output logic [CW-1:0] wr_data
);

  logic          ld_dly_q;
  logic          full_q;
  logic [CW-1:0] data_q;

  // While the delayed strobe is active the hold stage still shows the
  // character that was just moved, so no load may be taken then.
  assign ld = run && hold_full && !full_q && !ld_dly_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ld_dly_q <= 1'b0;
    end else begin
      ld_dly_q <= ld;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      full_q <= 1'b0;
    end else if (ld) begin
      full_q <= 1'b1;
    end else if (wr_fire) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (ld) begin
      data_q <= hold_data;
    end
  end

  assign at_mark  = mark_wm && (mark_char == GM_CODE);
  assign wr_valid = full_q && !at_mark;
  assign wr_fire  = wr_valid && wr_ready;
  assign ld_dly   = ld_dly_q;
  assign full_o   = full_q;
  assign wr_data  = data_q;

endmodule

// File: rtl/kin_seq.sv
// Operation sequencer: start, address stepping and the three endings.
module kin_seq
  import kin_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          key_release,
  input  logic          key_cancel,
  input  logic          hold_full,
  input  logic          xfer_full,
  input  logic          at_mark,
  input  logic          wr_fire,
  output logic          busy,
  output logic          accepting,
  output logic          run,
  output logic          flush,
  output logic [AW-1:0] addr,
  output logic          done,
  output logic [1:0]    end_code
);

  kin_state_t    st_q, st_d;
  logic [AW-1:0] addr_q;
  logic          done_q;
  kin_end_t      code_q, code_d;
  logic          cancel_hit, mark_hit, drain_hit, term;

  assign run        = (st_q == ST_RUN) || (st_q == ST_DRAIN);
  assign cancel_hit = run && key_cancel;
  assign mark_hit   = run && xfer_full && at_mark;
  assign drain_hit  = (st_q == ST_DRAIN) && !hold_full && !xfer_full;
  assign flush      = cancel_hit || mark_hit;
  assign term       = flush || drain_hit;

  // Cancel outranks a buffer-end hit, which outranks a finished drain.
  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_RUN;
          code_d = END_RELEASE;
        end
      end
      ST_RUN, ST_DRAIN: begin
        if (cancel_hit) begin
          st_d   = ST_IDLE;
          code_d = END_CANCEL;
        end else if (mark_hit) begin
          st_d   = ST_IDLE;
          code_d = END_BUFEND;
        end else if (drain_hit) begin
          st_d   = ST_IDLE;
          code_d = END_RELEASE;
        end else if (key_release) begin
          st_d   = ST_DRAIN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      code_q <= END_RELEASE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
      done_q <= term;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if ((st_q == ST_IDLE) && start) begin
      addr_q <= start_addr;
    end else if (wr_fire) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign accepting = (st_q == ST_RUN);
  assign addr      = addr_q;
  assign done      = done_q;
  assign end_code  = code_q;

endmodule

// File: rtl/kbd_stage_in.sv
module kbd_stage_in #(
  parameter int            CW      = 8,
  parameter int            AW      = 6,
  parameter logic [CW-1:0] GM_CODE = 8'h3A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          key_release,
  input  logic          key_cancel,
  output logic          busy,
  output logic          done,
  output logic [1:0]    end_code,
  input  logic          kb_valid,
  output logic          kb_ready,
  input  logic [CW-1:0] kb_data,
  output logic          hold_full,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [CW-1:0] wr_data,
  input  logic [CW-1:0] mark_char,
  input  logic          mark_wm
);

  logic          accepting, run, flush;
  logic          accept;
  logic          xfer_ld, xfer_ld_dly, xfer_full, at_mark, wr_fire;
  logic [CW-1:0] hold_data;

  // Ready also in the cycle the delayed clear lands: set wins there.
  assign kb_ready = accepting && (!hold_full || xfer_ld_dly);
  assign accept   = kb_valid && kb_ready;

  kin_hold_stage #(.CW(CW)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .set_i  (accept),
    .clr_i  (xfer_ld_dly),
    .din    (kb_data),
    .full_o (hold_full),
    .dout   (hold_data)
  );

  kin_xfer_stage #(.CW(CW), .GM_CODE(GM_CODE)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .run       (run),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .mark_char (mark_char),
    .mark_wm   (mark_wm),
    .wr_ready  (wr_ready),
    .ld        (xfer_ld),
    .ld_dly    (xfer_ld_dly),
    .full_o    (xfer_full),
    .at_mark   (at_mark),
    .wr_valid  (wr_valid),
    .wr_fire   (wr_fire),
    .wr_data   (wr_data)
  );

  kin_seq #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_addr  (start_addr),
    .key_release (key_release),
    .key_cancel  (key_cancel),
    .hold_full   (hold_full),
    .xfer_full   (xfer_full),
    .at_mark     (at_mark),
    .wr_fire     (wr_fire),
    .busy        (busy),
    .accepting   (accepting),
    .run         (run),
    .flush       (flush),
    .addr        (wr_addr),
    .done        (done),
    .end_code    (end_code)
  );

endmodule

// File: rtl/kbd_stage_in_chk.sv
module kbd_stage_in_chk #(
  parameter int            CW      = 8,
  parameter int            AW      = 6,
  parameter logic [CW-1:0] GM_CODE = 8'h3A
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          kb_valid,
  input logic          kb_ready,
  input logic          hold_full,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [CW-1:0] mark_char,
  input logic          mark_wm,
  input logic          key_cancel,
  input logic          ld,
  input logic          ld_dly,
  input logic          flush
);

  AST_FULL_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (kb_valid && kb_ready && !flush) |=> hold_full);  // R2

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> !ld);  // R3

  AST_CLEAR_ON_DELAY: assert property (@(posedge clk) disable iff (rst)
    (ld_dly && !(kb_valid && kb_ready)) |=> !hold_full);  // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (ld_dly && kb_valid && kb_ready && !flush) |=> hold_full);  // R5

  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !ld_dly) |-> !kb_ready);  // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (wr_addr == $past(wr_addr) + 1'b1));  // R7

  AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (rst)
    (busy && key_cancel) |=> (!busy && done && !wr_valid));  // R9

  AST_NO_WRITE_AT_MARK: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !(mark_wm && mark_char == GM_CODE));  // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!kb_ready && !wr_valid));  // R1

endmodule

bind kbd_stage_in kbd_stage_in_chk #(.CW(CW), .AW(AW), .GM_CODE(GM_CODE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .kb_valid   (kb_valid),
  .kb_ready   (kb_ready),
  .hold_full  (hold_full),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .mark_char  (mark_char),
  .mark_wm    (mark_wm),
  .key_cancel (key_cancel),
  .ld         (xfer_ld),
  .ld_dly     (xfer_ld_dly),
  .flush      (flush)
);

// File: tb/sim_kbd_stage_in.sv
module sim_kbd_stage_in;

  localparam int            CW      = 8;
  localparam int            AW      = 6;
  localparam logic [CW-1:0] GM      = 8'h3A;
  localparam int            DEPTH   = 1 << AW;
  localparam time           CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          key_release = 1'b0;
  logic          key_cancel = 1'b0;
  logic          busy, done;
  logic [1:0]    end_code;
  logic          kb_valid = 1'b0;
  logic          kb_ready;
  logic [CW-1:0] kb_data = '0;
  logic          hold_full;
  logic          wr_valid;
  logic          wr_ready = 1'b1;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic [CW-1:0] mark_char;
  logic          mark_wm;

  logic [CW-1:0] mem_c [DEPTH];
  logic          mem_w [DEPTH];
  int            wr_cnt = 0;
  int            total = 0;
  int            bad = 0;
  int            set_during_clr = 0;
  bit            finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  kbd_stage_in #(.CW(CW), .AW(AW), .GM_CODE(GM)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .key_release(key_release), .key_cancel(key_cancel),
    .busy(busy), .done(done), .end_code(end_code),
    .kb_valid(kb_valid), .kb_ready(kb_ready), .kb_data(kb_data),
    .hold_full(hold_full), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .mark_char(mark_char), .mark_wm(mark_wm)
  );

  assign mark_char = mem_c[wr_addr];
  assign mark_wm   = mem_w[wr_addr];

  always @(posedge clk) begin
    if (!rst && wr_valid && wr_ready) begin
      mem_c[wr_addr] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) begin
      mem_c[i] = 8'h00;
      mem_w[i] = 1'b0;
    end
  endtask

  // Called at a negedge; returns at a negedge after the character was taken.
  task automatic send(input logic [CW-1:0] c, input int limit, output bit ok);
    kb_valid = 1'b1;
    kb_data  = c;
    ok = 1'b0;
    for (int n = 0; n < limit; n++) begin
      if (kb_ready) begin
        if (hold_full) set_during_clr++;
        @(negedge clk);
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle_kb();
    kb_valid = 1'b0;
  endtask

  task automatic go(input logic [AW-1:0] a);
    start_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_release();
    key_release = 1'b1;
    @(negedge clk);
    key_release = 1'b0;
  endtask

  task automatic wait_done(input int limit, output int code, output bit seen);
    seen = 1'b0;
    code = -1;
    for (int n = 0; n < limit; n++) begin
      if (done) begin
        seen = 1'b1;
        code = int'(end_code);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 kb_ready", int'(kb_ready), 0);
    chk("R1 wr_valid", int'(wr_valid), 0);
    chk("R1 hold_full", int'(hold_full), 0);
  endtask

  task automatic t_basic();
    bit ok, seen;
    int code;
    clear_mem();
    wr_ready = 1'b1;
    go(6'd5);
    send(8'h41, 20, ok);
    idle_kb();
    chk("R2 hold_full after accept", int'(hold_full), 1);
    @(negedge clk);
    chk("R4 hold_full second cycle", int'(hold_full), 1);
    @(negedge clk);
    chk("R4 hold_full released", int'(hold_full), 0);
    go(6'd40);  // R11 start while busy
    send(8'h42, 20, ok);
    idle_kb();
    repeat (3) @(negedge clk);
    send(8'h43, 20, ok);
    idle_kb();
    repeat (4) @(negedge clk);
    pulse_release();
    chk("R8 ready dropped after release", int'(kb_ready), 0);
    wait_done(20, code, seen);
    chk("R8 done seen", int'(seen), 1);
    chk("R8 end code release", code, 0);
    chk("R7 addr5", int'(mem_c[5]), 8'h41);
    chk("R7 addr6", int'(mem_c[6]), 8'h42);
    chk("R11 addr7 despite start", int'(mem_c[7]), 8'h43);
    chk("R11 addr40 untouched", int'(mem_c[40]), 0);
    chk("R3 write count basic", wr_cnt, 3);
  endtask

  task automatic t_stream();
    bit ok, seen;
    int code, base;
    clear_mem();
    base = wr_cnt;
    set_during_clr = 0;
    wr_ready = 1'b1;
    go(6'd10);
    for (int k = 0; k < 6; k++) begin
      send(8'h50 + 8'(k), 20, ok);
      chk("R6 streamed char accepted", int'(ok), 1);
    end
    idle_kb();
    chk("R5 accepted during delayed clear", int'(set_during_clr > 0), 1);
    pulse_release();
    wait_done(30, code, seen);
    chk("R8 stream done", int'(seen), 1);
    for (int k = 0; k < 6; k++)
      chk("R5 stream order", int'(mem_c[10 + k]), 8'h50 + k);
    chk("R3 one write per char", wr_cnt - base, 6);
  endtask

  task automatic t_backpressure();
    bit ok, seen;
    int code, base, rdy_seen;
    clear_mem();
    base = wr_cnt;
    wr_ready = 1'b0;
    go(6'd30);
    send(8'h61, 20, ok);
    send(8'h62, 20, ok);
    kb_valid = 1'b1;
    kb_data  = 8'h63;
    rdy_seen = 0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 8; n++) begin
      if (kb_ready) rdy_seen++;
      @(negedge clk);
    end
    chk("R6 ready held low while full", rdy_seen, 0);
    wr_ready = 1'b1;
    send(8'h63, 20, ok);
    idle_kb();
    chk("R6 held char accepted", int'(ok), 1);
    repeat (6) @(negedge clk);
    pulse_release();
    wait_done(20, code, seen);
    chk("R6 char1", int'(mem_c[30]), 8'h61);
    chk("R6 char2", int'(mem_c[31]), 8'h62);
    chk("R6 char3", int'(mem_c[32]), 8'h63);
    chk("R3 backpressure writes", wr_cnt - base, 3);
  endtask

  task automatic t_cancel();
    bit ok, seen;
    int code, base;
    clear_mem();
    wr_ready = 1'b0;
    go(6'd50);
    send(8'h71, 20, ok);
    send(8'h72, 20, ok);
    idle_kb();
    repeat (2) @(negedge clk);
    base = wr_cnt;
    key_cancel = 1'b1;
    @(negedge clk);
    key_cancel = 1'b0;
    wait_done(3, code, seen);
    chk("R9 done seen", int'(seen), 1);
    chk("R9 end code cancel", code, 1);
    chk("R9 busy low", int'(busy), 0);
    wr_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 no write after cancel", wr_cnt - base, 0);
    chk("R9 slot empty", int'(mem_c[50]), 0);
  endtask

  task automatic t_bufend();
    bit ok, seen;
    int code, base;
    clear_mem();
    mem_c[23] = GM;
    mem_w[23] = 1'b1;
    mem_c[21] = GM;  // group mark without word mark: ordinary slot
    base = wr_cnt;
    wr_ready = 1'b1;
    go(6'd20);
    for (int k = 0; k < 3; k++) send(8'h30 + 8'(k), 20, ok);
    send(8'h39, 20, ok);
    idle_kb();
    wait_done(20, code, seen);
    chk("R10 done seen", int'(seen), 1);
    chk("R10 end code bufend", code, 2);
    chk("R10 busy low", int'(busy), 0);
    chk("R10 marked slot kept", int'(mem_c[23]), int'(GM));
    chk("R10 slot before mark written", int'(mem_c[22]), 8'h32);
    chk("R10 unmarked gm overwritten", int'(mem_c[21]), 8'h31);
    chk("R10 writes before mark", wr_cnt - base, 3);
    send(8'h3F, 5, ok);
    idle_kb();
    chk("R10 no accept after end", int'(ok), 0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_basic();
    t_stream();
    t_backpressure();
    t_cancel();
    t_bufend();
    finished = 1'b1;
  end

  initial begin
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (finished) break;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule